// File: doc/BRIEF.md
# Cascadable Serial-In Latched-Output LED Sink Driver

This block turns a serial bit stream into eight parallel sink controls for an LED display. Bits arrive one per rising edge of a shift clock and move through an internal shift register. A separate storage clock copies that register into a holding register, and the holding register drives the outputs. This lets the display keep a steady pattern while the next pattern is being shifted in.

Each output is a sink-enable. A value of 1 means the open-drain stage conducts and pulls its LED line low, so the LED lights. An active-low gate input can switch all eight sinks off at once. The last shift stage is also brought out as a serial output. Several blocks can then be chained, each one's serial output feeding the next one's serial input.

An active-low clear empties only the shift register. A power-on reset empties both registers.

Top module: `led_sink_chain`

## Requirements
- R1: While and after the power-on reset `rst_n` is low, `sink_en` is all zeros and `data_out` is 0.
- R2: On each rising edge of `shift_clk`, `data_in` enters bit 0 of the shift register and every bit moves up one place. The first bit entered reaches `data_out` after the eighth edge and not before.
- R3: On a rising edge of `store_clk`, the shift register contents are copied into the holding register. Shifting alone never changes `sink_en`.
- R4: While `clr_n` is low, the shift register is held at zero asynchronously and `data_out` is 0. The holding register and `sink_en` are unaffected.
- R5: While `oe_n` is 1, all bits of `sink_en` are 0, whatever is held.
- R6: While `oe_n` is 0, `sink_en[i]` equals bit i of the holding register. A byte shifted in most significant bit first therefore shows up on `sink_en` with the same bit positions.
- R7: `data_out` is changed by neither `store_clk` nor `oe_n`.
- R8: A `shift_clk` edge that occurs while `clr_n` is low leaves the shift register at zero; the clear wins.
- R9: When a second byte is shifted in after a first one, `data_out` emits the first byte, most significant bit first, one bit per edge. This is what a chained block receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low, clears both registers |
| shift_clk | input | 1 | Shift clock, rising edge active |
| clr_n | input | 1 | Asynchronous shift register clear, active low |
| data_in | input | 1 | Serial data input |
| store_clk | input | 1 | Storage clock, rising edge copies the shift register into the holding register |
| oe_n | input | 1 | Output gate, active low |
| sink_en | output | WIDTH | Per-output sink enable, 1 means the LED line is pulled low |
| data_out | output | 1 | Serial output from the last shift stage, for chaining |

## Verification
Both registers update on the rising edge of their own clock with no extra pipeline stage:
- `data_out` is due at the shift edge itself.
- `sink_en` is due at the storage edge itself.
- The gate and the clear act with no clock.

The bench applies each clock pulse as a high phase followed by a low phase, and it samples only in that low phase, after the data has settled. Each check therefore sees the result of exactly the edges already driven. The checker also samples on falling edges, away from the active edge.

// File: rtl/led_sink_chain.sv
module led_sink_chain #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             shift_clk,
  input  logic             clr_n,
  input  logic             data_in,
  input  logic             store_clk,
  input  logic             oe_n,
  output logic [WIDTH-1:0] sink_en,
  output logic             data_out
);

  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] hold_q;
  logic             empty_n;

  assign empty_n = rst_n & clr_n;

  always_ff @(posedge shift_clk or negedge empty_n) begin
    if (!empty_n) shift_q <= '0;
    else          shift_q <= {shift_q[WIDTH-2:0], data_in};
  end

  always_ff @(posedge store_clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= shift_q;
  end

  assign sink_en  = oe_n ? '0 : hold_q;
  assign data_out = shift_q[WIDTH-1];

endmodule

module led_sink_chain_chk #(
  parameter int WIDTH = 8
) (
  input logic             rst_n,
  input logic             shift_clk,
  input logic             clr_n,
  input logic             data_in,
  input logic             store_clk,
  input logic             oe_n,
  input logic [WIDTH-1:0] sink_en,
  input logic             data_out,
  input logic [WIDTH-1:0] shift_q
);

  logic [WIDTH-1:0] snap_q;
  logic             snap_ok;

  always_ff @(posedge store_clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      snap_ok <= 1'b0;
    end else begin
      snap_q  <= shift_q;
      snap_ok <= 1'b1;
    end
  end

  assert_shift_step_R2: assert property (@(posedge shift_clk) disable iff (!rst_n || !clr_n)
    1'b1 |=> (shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0])) && (shift_q[0] == $past(data_in)));

  always @(negedge store_clk) begin
    if (rst_n && snap_ok && !oe_n)
      assert_transfer_R3: assert (sink_en == snap_q);
    if (rst_n && oe_n)
      assert_gate_off_R5: assert (sink_en == '0);
  end

  always @(negedge shift_clk) begin
    if (rst_n && !clr_n)
      assert_clear_empty_R4: assert (shift_q == '0 && data_out == 1'b0);
  end

endmodule

bind led_sink_chain led_sink_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_n(rst_n), .shift_clk(shift_clk), .clr_n(clr_n), .data_in(data_in),
  .store_clk(store_clk), .oe_n(oe_n), .sink_en(sink_en), .data_out(data_out),
  .shift_q(shift_q)
);

// File: tb/led_sink_chain_tb.sv
module led_sink_chain_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, shift_clk = 1'b0, clr_n = 1'b1, data_in = 1'b0;
  logic store_clk = 1'b0, oe_n = 1'b0;
  logic [W-1:0] sink_en;
  logic data_out;
  int runs = 0, fails = 0;

  led_sink_chain #(.WIDTH(W)) u_dut (
    .rst_n(rst_n), .shift_clk(shift_clk), .clr_n(clr_n), .data_in(data_in),
    .store_clk(store_clk), .oe_n(oe_n), .sink_en(sink_en), .data_out(data_out)
  );

  localparam logic [W-1:0] PAT [6] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h3C};

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_one(input logic b);
    data_in = b;
    @(negedge clk); shift_clk = 1'b1;
    @(negedge clk); shift_clk = 1'b0;
    #2;
  endtask

  task automatic send_byte(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) shift_one(v[i]);
  endtask

  task automatic store;
    @(negedge clk); store_clk = 1'b1;
    @(negedge clk); store_clk = 1'b0;
    #2;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    logic keep;
    repeat (3) @(negedge clk);
    chk("R1 sink_en in reset", sink_en, '0);
    chk("R1 data_out in reset", {7'b0, data_out}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sink_en after reset", sink_en, '0);

    foreach (PAT[k]) begin
      send_byte(PAT[k]);
      oe_n = 1'b0; store;
      chk("R6 pattern on sink_en", sink_en, PAT[k]);
      oe_n = 1'b1; #1;
      chk("R5 gated off", sink_en, '0);
      oe_n = 1'b0; #1;
    end

    send_byte(8'h00); store;
    shift_one(1'b1);
    for (int i = 1; i < W; i++) begin
      chk("R2 first bit not yet out", {7'b0, data_out}, '0);
      shift_one(1'b0);
    end
    chk("R2 first bit out after eighth edge", {7'b0, data_out}, 8'h01);
    chk("R3 shifting leaves sink_en", sink_en, '0);
    store;
    chk("R3 store copies register", sink_en, 8'h80);

    send_byte(8'hC3); store;
    send_byte(8'h5A);
    @(negedge clk); clr_n = 1'b0; #2;
    chk("R4 clear empties serial out", {7'b0, data_out}, '0);
    chk("R4 clear keeps sink_en", sink_en, 8'hC3);
    shift_one(1'b1);
    chk("R8 shift under clear stays empty", {7'b0, data_out}, '0);
    @(negedge clk); clr_n = 1'b1; #2;
    store;
    chk("R8 stored after clear is zero", sink_en, '0);

    send_byte(8'h80);
    keep = data_out;
    store;
    chk("R7 store_clk leaves data_out", {7'b0, data_out}, {7'b0, keep});
    oe_n = 1'b1; #1;
    chk("R7 oe_n leaves data_out", {7'b0, data_out}, {7'b0, keep});
    chk("R5 gate with held ones", sink_en, '0);
    oe_n = 1'b0; #1;
    chk("R6 gate released", sink_en, 8'h80);

    send_byte(8'hB6);
    got = '0;
    for (int i = W - 1; i >= 0; i--) begin
      got[i] = data_out;
      shift_one(1'b0);
    end
    chk("R9 chained stream", got, 8'hB6);

    @(negedge clk); rst_n = 1'b0; #2;
    chk("R1 reset clears held pattern", sink_en, '0);
    chk("R1 reset clears serial out", {7'b0, data_out}, '0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule